// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a four-beat synchronous memory burst. When either of two active-low address strobes is sampled on a rising clock edge, the full external address is captured. The processor-side strobe counts only when the first chip select is active. The controller-side strobe always counts. After the capture, a two-bit beat counter steps the two lowest address bits on each edge where the active-low advance input is asserted. The upper address bits stay frozen for the whole burst.

A mode input picks the beat order. With mode high, the order is interleaved: the low bits are the start bits XOR the beat count. With mode low, the order is linear: the low bits are the start bits plus the beat count, modulo four. After four advances the address wraps back to where the burst began and does not move into the next four-word block. The outputs are the current array address and the beat index.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset clears the captured address and the beat count, so `addr_out` and `beat` are zero on the cycle after a reset edge. Reset takes priority over every strobe.
- R2: On an edge where `strb_ctl_n` is low, the full `addr_in` is captured and `beat` becomes 0, whatever the state of `sel1_n` and `adv_n`.
- R3: `strb_cpu_n` low loads the address only when `sel1_n` is low. When `sel1_n` is high, the processor strobe has no effect and the sequencer holds or advances as if no strobe were present.
- R4: On an edge with no effective strobe and `adv_n` low, `beat` increments by one modulo 4.
- R5: On an edge with no effective strobe and `adv_n` high, `beat` and `addr_out` hold their values, which suspends the burst.
- R6: `addr_out[AW-1:2]` stays unchanged across every edge without an effective strobe.
- R7: With `order_il` high, `addr_out[1:0]` equals the captured start bits XOR `beat`.
- R8: With `order_il` low, `addr_out[1:0]` equals the captured start bits plus `beat`, modulo 4.
- R9: After four advances from a load, `addr_out` equals the captured start address again.
- R10: A strobe in the middle of a burst restarts the sequence. `beat` returns to 0 at the newly captured address, and the strobe wins over an asserted advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | AW | External address, captured on a strobe |
| strb_cpu_n | input | 1 | Processor address strobe, active low, qualified by `sel1_n` |
| strb_ctl_n | input | 1 | Controller address strobe, active low, always honoured |
| sel1_n | input | 1 | First chip select, active low; gates the processor strobe |
| adv_n | input | 1 | Advance request, active low |
| order_il | input | 1 | 1 = interleaved beat order, 0 = linear beat order |
| addr_out | output | AW | Current array word address |
| beat | output | 2 | Beat index within the burst |

## Verification
Bursts are started at each of the four start offsets under both orders, so that an XOR-based order cannot be mistaken for an additive one. This matters for offsets 1 and 3, where the two orders differ. Advance pulses are interleaved with idle cycles to separate hold from step, and bursts run through a full wrap. The processor strobe is pulsed with the chip select both active and inactive. Strobes land in mid-burst with advance asserted, which exposes any wrong priority between load and step. A long stretch of mixed stimulus is then compared against a behavioural model on every clock.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_in,
  input  logic          strb_cpu_n,
  input  logic          strb_ctl_n,
  input  logic          sel1_n,
  input  logic          adv_n,
  input  logic          order_il,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    beat
);

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          load;
  logic [1:0]    lo_il, lo_lin;

  assign load = ~strb_ctl_n | (~strb_cpu_n & ~sel1_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= addr_in;
      cnt_q  <= '0;
    end else if (!adv_n) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  assign lo_il    = base_q[1:0] ^ cnt_q;
  assign lo_lin   = base_q[1:0] + cnt_q;
  assign addr_out = {base_q[AW-1:2], order_il ? lo_il : lo_lin};
  assign beat     = cnt_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_in,
  input logic          strb_cpu_n,
  input logic          strb_ctl_n,
  input logic          sel1_n,
  input logic          adv_n,
  input logic          order_il,
  input logic [AW-1:0] addr_out,
  input logic [1:0]    beat
);

  logic       eff_load;
  logic [1:0] start_lo;

  assign eff_load = !strb_ctl_n || (!strb_cpu_n && !sel1_n);

  always_ff @(posedge clk) begin
    if (rst)           start_lo <= 2'd0;
    else if (eff_load) start_lo <= addr_in[1:0];
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (beat == 2'd0 && addr_out == '0));

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    !strb_ctl_n |=> (beat == 2'd0 && addr_out[AW-1:2] == $past(addr_in[AW-1:2])));

  // R3
  cpu_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb_cpu_n && sel1_n && strb_ctl_n && adv_n) |=> $stable(beat));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (!eff_load && !adv_n) |=> beat == 2'($past(beat) + 2'd1));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!eff_load && adv_n) |=> $stable(beat));

  // R6
  upper_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !eff_load |=> $stable(addr_out[AW-1:2]));

  // R7
  il_order_chk: assert property (@(posedge clk) disable iff (rst)
    order_il |-> addr_out[1:0] == (start_lo ^ beat));

  // R8
  lin_order_chk: assert property (@(posedge clk) disable iff (rst)
    !order_il |-> addr_out[1:0] == 2'(start_lo + beat));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .addr_in(addr_in), .strb_cpu_n(strb_cpu_n),
  .strb_ctl_n(strb_ctl_n), .sel1_n(sel1_n), .adv_n(adv_n),
  .order_il(order_il), .addr_out(addr_out), .beat(beat)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, sel1_n = 1'b1;
  logic          adv_n = 1'b1, order_il = 1'b1;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] m_base = '0;
  int            m_cnt = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .addr_in(addr_in), .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n), .sel1_n(sel1_n), .adv_n(adv_n),
    .order_il(order_il), .addr_out(addr_out), .beat(beat)
  );

  function automatic logic [AW-1:0] model_addr();
    int lo;
    if (order_il) lo = int'(m_base[1:0]) ^ m_cnt;
    else          lo = (int'(m_base[1:0]) + m_cnt) % 4;
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    if (rst) begin
      m_base = '0; m_cnt = 0;
    end else if (!strb_ctl_n || (!strb_cpu_n && !sel1_n)) begin
      m_base = addr_in; m_cnt = 0;
    end else if (!adv_n) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    @(negedge clk);
    check({tag, " addr"}, addr_out, model_addr());
    check({tag, " beat"}, {{(AW-2){1'b0}}, beat}, AW'(m_cnt));
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
  endtask

  task automatic load_ctl(logic [AW-1:0] a, string tag);
    addr_in = a; strb_ctl_n = 1'b0; adv_n = 1'b0;
    cyc(tag);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] st;
    @(negedge clk);
    strb_ctl_n = 1'b0; addr_in = 17'h1ABCD;
    cyc("R1");
    cyc("R1");
    check("R1 reset addr zero", addr_out, '0);
    rst = 1'b0;

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        order_il = (m == 0);
        st = {15'h2A5C + 15'(s), 2'(s)};
        load_ctl(st, "R2");
        for (int k = 0; k < 4; k++) begin
          adv_n = 1'b0;
          cyc(order_il ? "R7" : "R8");
          if (k < 3) begin
            adv_n = 1'b1;
            cyc("R5");
          end
        end
        check("R9 wrap to start", addr_out, st);
        check("R6 upper frozen", {addr_out[AW-1:2], 2'b00}, {st[AW-1:2], 2'b00});
      end
    end

    order_il = 1'b1;
    load_ctl(17'h00013, "R2");
    adv_n = 1'b0; cyc("R4");
    addr_in = 17'h1F0F2; strb_cpu_n = 1'b0; sel1_n = 1'b1; adv_n = 1'b0;
    cyc("R3 cpu ignored");
    check("R3 cpu ignored upper", {addr_out[AW-1:2], 2'b00}, 17'h00010);
    strb_cpu_n = 1'b0; sel1_n = 1'b0; addr_in = 17'h0ACE1;
    cyc("R3 cpu load");
    check("R3 cpu load", addr_out, 17'h0ACE1);
    adv_n = 1'b0; cyc("R4");
    adv_n = 1'b0; addr_in = 17'h05556; strb_ctl_n = 1'b0; sel1_n = 1'b1;
    cyc("R10 restart");
    check("R10 restart beat", {{(AW-2){1'b0}}, beat}, '0);
    check("R10 restart addr", addr_out, 17'h05556);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      addr_in    = AW'(r >> 4);
      strb_ctl_n = (r[3:0] != 4'd0);
      strb_cpu_n = (r[7:4] > 4'd2);
      sel1_n     = r[8];
      adv_n      = r[9] & r[10];
      order_il   = r[11];
      rst        = (r[31:20] == 12'd7);
      cyc("R10 mixed");
      rst = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule